// File: doc/BRIEF.md
# Raster Position Interrupt Generator

This block raises an active-low CPU interrupt shortly before video rendering reaches a horizontal and vertical position that software has programmed. It keeps its own dot and scanline counters, clocked once per PPU dot and brought back to the top-left corner by a frame-start pulse. The CPU programs a horizontal target code, a vertical target code and an enable bit through a small four-address register window. It clears the interrupt through a status register.

The interrupt is raised a fixed 42 dots (14 CPU cycles) ahead of the target. The interrupt handler then burns the remaining, variable part of the delay in software and lands on the exact pixel. The horizontal code has two-pixel resolution, so one byte spans the visible line. The vertical code 255 selects the last scanline before the vertical-blank NMI line. No interrupt is produced in the first six scanlines of vertical blank, and at most one is produced per frame.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset `irq_n` is 1 and all four register addresses read 0x00.
- R2: Address 0 holds the horizontal code and address 1 holds the vertical code, and both read back as written. Address 2 bit 0 is the enable bit. A read of address 3 returns bit 7 = interrupt pending and bit 6 = fired in this frame, with the other bits 0.
- R3: The dot counter runs from 0 to 340 and the line counter from 0 to 261, and both wrap on their own. A cycle with `frame_start` high puts the position at dot 0, line 0 in the following cycle.
- R4: The target dot is twice the horizontal code, and codes above 170 act as 170. The target line equals the vertical code, except that code 255 selects line 240, the line just before the NMI line 241.
- R5: Count the clock edge that samples `frame_start` as edge 0, and let the fire position F = target line × 341 + target dot − 42. Then `irq_n` first reads 0 after edge F+1 and still reads 1 after edge F.
- R6: When the target dot is below 42, the fire point moves to the previous line at target dot + 299. A target on line 0 fires on line 261.
- R7: A fire point that falls on lines 241 to 246 produces no interrupt.
- R8: While the enable bit is 0, no interrupt is raised.
- R9: After one interrupt, no further interrupt is raised until the next `frame_start` or natural frame wrap, even if the targets are rewritten.
- R10: `irq_n` stays 0 until a read of address 3 or a write to address 3. It returns to 1 at the following edge, unless a new fire occurs in that same cycle, in which case the fire wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PPU dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that restarts the position at dot 0, line 0 |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (a read of address 3 clears the pending interrupt) |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, a combinational function of `cpu_addr` |
| irq_n | output | 1 | Active-low interrupt request, held until cleared |

## Verification
The bench places targets that force the lead subtraction across a line boundary, including the move from line 0 back into line 261. A design that mishandles this fires hundreds of dots late or never. It programs a fire point inside the blocked vertical-blank lines and a clamped horizontal code, which a careless design would turn into a missed or out-of-range compare. It rewrites the targets after a fire, which a design without a per-frame latch answers with a second interrupt. It also checks the vertical code 255 mapping: a design that decodes it literally never fires.

// File: rtl/rirq_pkg.sv
// Package: shared register map and status layout for the raster interrupt generator.
// Assumes an 8-bit CPU data path and a 2-bit register address.
package rirq_pkg;

    localparam int REG_W          = 8;
    localparam int CTRL_EN_BIT    = 0;
    localparam int STAT_PEND_BIT  = 7;
    localparam int STAT_FIRED_BIT = 6;

    typedef enum logic [1:0] {
        RA_XPOS = 2'd0,
        RA_YPOS = 2'd1,
        RA_CTRL = 2'd2,
        RA_STAT = 2'd3
    } rirq_addr_e;

endpackage

// File: rtl/rirq_beam.sv
// Module: rirq_beam
// Tracks the current dot and scanline of the raster, one dot per clock.
// Assumes frame_start is a single-cycle pulse; without it the counters wrap freely.
module rirq_beam #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int DOT_W           = $clog2(DOTS_PER_LINE),
    parameter int LINE_W          = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line,
    output logic              wrap
);
    localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);

    logic [DOT_W-1:0]  dot_q;
    logic [LINE_W-1:0] line_q;

    // Last dot of the last line: next cycle starts a new frame.
    always_comb wrap = (dot_q == LAST_DOT) && (line_q == LAST_LINE);

    // Advance the position, restarting on frame_start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_q  <= '0;
            line_q <= '0;
        end else if (frame_start) begin
            dot_q  <= '0;
            line_q <= '0;
        end else if (dot_q == LAST_DOT) begin
            dot_q  <= '0;
            line_q <= (line_q == LAST_LINE) ? '0 : line_q + LINE_W'(1);
        end else begin
            dot_q <= dot_q + DOT_W'(1);
        end
    end

    assign dot  = dot_q;
    assign line = line_q;

    // R3
    restart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (dot_q == '0 && line_q == '0));

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_q <= LAST_DOT) && (line_q <= LAST_LINE));

endmodule

// File: rtl/rirq_target_map.sv
// Module: rirq_target_map
// Turns the programmed codes into the dot/line at which the interrupt must fire,
// applying the fixed lead and the vertical-blank block window.
// Assumes LEAD_DOTS < DOTS_PER_LINE and that 2*code fits the dot width.
module rirq_target_map #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VBL_LINE        = 241,
    parameter int BLOCK_LINES     = 6,
    parameter int LEAD_DOTS       = 42,
    parameter int DOT_W           = $clog2(DOTS_PER_LINE),
    parameter int LINE_W          = $clog2(LINES_PER_FRAME)
) (
    input  logic [7:0]        x_code,
    input  logic [7:0]        y_code,
    output logic [DOT_W-1:0]  fire_dot,
    output logic [LINE_W-1:0] fire_line,
    output logic              fire_blocked
);
    localparam logic [7:0]        XMAX      = 8'((DOTS_PER_LINE - 1) / 2);
    localparam logic [DOT_W-1:0]  LEAD_D    = DOT_W'(LEAD_DOTS);
    localparam logic [DOT_W-1:0]  BACK_D    = DOT_W'(DOTS_PER_LINE - LEAD_DOTS);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);
    localparam logic [LINE_W-1:0] PRE_VBL   = LINE_W'(VBL_LINE - 1);
    localparam logic [LINE_W-1:0] BLK_LO    = LINE_W'(VBL_LINE);
    localparam logic [LINE_W-1:0] BLK_HI    = LINE_W'(VBL_LINE + BLOCK_LINES);

    logic [7:0]        xc;
    logic [DOT_W-1:0]  tdot;
    logic [LINE_W-1:0] tline;

    // Clamp and scale the codes to a raster target.
    always_comb begin
        xc    = (x_code > XMAX) ? XMAX : x_code;
        tdot  = DOT_W'({xc, 1'b0});
        tline = (y_code == 8'hFF) ? PRE_VBL : LINE_W'(y_code);
    end

    // Subtract the lead, borrowing from the previous line when needed.
    always_comb begin
        if (tdot >= LEAD_D) begin
            fire_dot  = tdot - LEAD_D;
            fire_line = tline;
        end else begin
            fire_dot  = tdot + BACK_D;
            fire_line = (tline == '0) ? LAST_LINE : tline - LINE_W'(1);
        end
        fire_blocked = (fire_line >= BLK_LO) && (fire_line < BLK_HI);
    end

endmodule

// File: rtl/rirq_regs.sv
// Module: rirq_regs
// CPU-visible registers plus the pending-interrupt and fired-this-frame flags.
// Assumes single-cycle read/write strobes; reads are combinational on the address.
module rirq_regs
    import rirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             fire_hit,
    input  logic             frame_clear,
    output logic [REG_W-1:0] rdata,
    output logic [7:0]       x_code,
    output logic [7:0]       y_code,
    output logic             enable,
    output logic             fired,
    output logic             irq_n
);
    logic [7:0] x_q, y_q;
    logic       en_q, pend_q, fired_q, clr_req;

    // Any access to the status address acknowledges the interrupt.
    always_comb clr_req = (wr_en || rd_en) && (rirq_addr_e'(addr) == RA_STAT);

    // Store programmed targets and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            en_q <= 1'b0;
        end else if (wr_en) begin
            case (rirq_addr_e'(addr))
                RA_XPOS: x_q  <= wdata;
                RA_YPOS: y_q  <= wdata;
                RA_CTRL: en_q <= wdata[CTRL_EN_BIT];
                default: ;
            endcase
        end
    end

    // Hold the interrupt until acknowledged; a fresh fire wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (fire_hit) pend_q <= 1'b1;
        else if (clr_req)  pend_q <= 1'b0;
    end

    // Remember a fire until the frame restarts.
    always_ff @(posedge clk) begin
        if (!rst_n)           fired_q <= 1'b0;
        else if (frame_clear) fired_q <= 1'b0;
        else if (fire_hit)    fired_q <= 1'b1;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (rirq_addr_e'(addr))
            RA_XPOS: rdata = x_q;
            RA_YPOS: rdata = y_q;
            RA_CTRL: rdata[CTRL_EN_BIT] = en_q;
            RA_STAT: begin
                rdata[STAT_PEND_BIT]  = pend_q;
                rdata[STAT_FIRED_BIT] = fired_q;
            end
            default: rdata = '0;
        endcase
    end

    assign x_code = x_q;
    assign y_code = y_q;
    assign enable = en_q;
    assign fired  = fired_q;
    assign irq_n  = ~pend_q;

    // R8
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(en_q));

    // R9
    once_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> !$past(fired_q));

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !fire_hit) |=> !pend_q);

endmodule

// File: rtl/raster_irq_gen.sv
// Module: raster_irq_gen (top)
// Raises irq_n a fixed lead ahead of a programmed raster position, once per frame,
// never inside the first scanlines of vertical blank.
// Assumes clk is the PPU dot clock and frame_start marks dot 0 of line 0.
module raster_irq_gen #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VBL_LINE        = 241,
    parameter int BLOCK_LINES     = 6,
    parameter int LEAD_DOTS       = 42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [1:0] cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       irq_n
);
    localparam int DOT_W  = $clog2(DOTS_PER_LINE);
    localparam int LINE_W = $clog2(LINES_PER_FRAME);
    localparam logic [LINE_W-1:0] BLK_LO = LINE_W'(VBL_LINE);
    localparam logic [LINE_W-1:0] BLK_HI = LINE_W'(VBL_LINE + BLOCK_LINES);

    logic [DOT_W-1:0]  dot, fire_dot;
    logic [LINE_W-1:0] line, fire_line;
    logic              wrap, fire_blocked, fire_hit, frame_clear;
    logic [7:0]        x_code, y_code;
    logic              enable, fired;

    rirq_beam #(
        .DOTS_PER_LINE  (DOTS_PER_LINE),
        .LINES_PER_FRAME(LINES_PER_FRAME),
        .DOT_W          (DOT_W),
        .LINE_W         (LINE_W)
    ) u_beam (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .dot        (dot),
        .line       (line),
        .wrap       (wrap)
    );

    rirq_target_map #(
        .DOTS_PER_LINE  (DOTS_PER_LINE),
        .LINES_PER_FRAME(LINES_PER_FRAME),
        .VBL_LINE       (VBL_LINE),
        .BLOCK_LINES    (BLOCK_LINES),
        .LEAD_DOTS      (LEAD_DOTS),
        .DOT_W          (DOT_W),
        .LINE_W         (LINE_W)
    ) u_map (
        .x_code      (x_code),
        .y_code      (y_code),
        .fire_dot    (fire_dot),
        .fire_line   (fire_line),
        .fire_blocked(fire_blocked)
    );

    // Fire when the beam sits on the fire point and nothing suppresses it.
    always_comb begin
        fire_hit = enable && !fired && !fire_blocked && !frame_start
                   && (dot == fire_dot) && (line == fire_line);
        frame_clear = frame_start || wrap;
    end

    rirq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cpu_wr),
        .rd_en      (cpu_rd),
        .addr       (cpu_addr),
        .wdata      (cpu_wdata),
        .fire_hit   (fire_hit),
        .frame_clear(frame_clear),
        .rdata      (cpu_rdata),
        .x_code     (x_code),
        .y_code     (y_code),
        .enable     (enable),
        .fired      (fired),
        .irq_n      (irq_n)
    );

    // R7
    vblank_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(line) < BLK_LO || $past(line) >= BLK_HI));

endmodule

// File: tb/test_raster_irq_gen.sv
// Scoreboard bench: the driver queues the expected interrupt edge (frame-relative
// cycle) and the monitor pops and compares it on every falling irq_n.
module test_raster_irq_gen;

    logic       clk = 1'b0;
    logic       rst_n, frame_start, cpu_wr, cpu_rd;
    logic [1:0] cpu_addr;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic       irq_n;

    int total = 0;
    int bad   = 0;
    int rel   = 0;
    logic irq_d = 1'b1;

    typedef struct { int at; string tag; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    raster_irq_gen i_raster_irq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .irq_n      (irq_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Frame-relative cycle count: zero right after the edge sampling frame_start.
    always @(posedge clk) rel <= frame_start ? 0 : rel + 1;

    // Monitor: compare each interrupt edge against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && irq_d && !irq_n) begin
            if (sb.size() == 0) begin
                check(1'b0, "unexpected irq (R7/R8/R9)", rel, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rel == e.at, e.tag, rel, e.at);
            end
        end
        irq_d = irq_n;
    end

    task automatic expect_fire(input int at, input string tag);
        exp_t e;
        e.at = at;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic wait_rel(input int n);
        while (rel < n) @(negedge clk);
    endtask

    task automatic set_target(input logic [7:0] x, input logic [7:0] y);
        reg_wr(2'd0, x);
        reg_wr(2'd1, y);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (199000) @(posedge clk);
        check(1'b0, "R5 watchdog", rel, -1);
        finish_run();
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; frame_start = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
        cpu_addr = '0; cpu_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(irq_n == 1'b1, "R1 irq_n", int'(irq_n), 1);
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), d);
            check(d == 8'h00, "R1 reg", int'(d), 0);
        end

        // R2: readback
        reg_wr(2'd0, 8'h5A); reg_rd(2'd0, d);
        check(d == 8'h5A, "R2 xpos", int'(d), 'h5A);
        reg_wr(2'd1, 8'hC3); reg_rd(2'd1, d);
        check(d == 8'hC3, "R2 ypos", int'(d), 'hC3);
        reg_wr(2'd2, 8'h01); reg_rd(2'd2, d);
        check(d == 8'h01, "R2 ctrl", int'(d), 1);

        // R5/R3: line 2 dot 100 -> fire position 740
        set_target(8'd50, 8'd2);
        expect_fire(741, "R5 lead timing");
        pulse_frame();
        wait_rel(740);
        check(irq_n == 1'b1, "R5 not early", int'(irq_n), 1);
        wait_rel(760);
        check(sb.size() == 0, "R3 fire seen", sb.size(), 0);
        check(irq_n == 1'b0, "R10 held", int'(irq_n), 0);
        reg_rd(2'd3, d);
        check(d == 8'hC0, "R2 status", int'(d), 'hC0);
        check(irq_n == 1'b1, "R10 read clears", int'(irq_n), 1);

        // R6: dot 20 on line 3 borrows into line 2 dot 319 -> 1001
        set_target(8'd10, 8'd3);
        expect_fire(1002, "R6 line borrow");
        pulse_frame();
        wait_rel(1010);
        check(sb.size() == 0, "R6 fire seen", sb.size(), 0);
        reg_wr(2'd3, 8'h00);
        check(irq_n == 1'b1, "R10 write ack", int'(irq_n), 1);

        // R4: code 200 clamps to 170 -> dot 340, line 1 -> 639
        set_target(8'd200, 8'd1);
        expect_fire(640, "R4 clamp");
        pulse_frame();
        wait_rel(700);
        check(sb.size() == 0, "R4 fire seen", sb.size(), 0);
        reg_wr(2'd3, 8'h00);

        // R8: disabled
        reg_wr(2'd2, 8'h00);
        set_target(8'd60, 8'd1);
        pulse_frame();
        wait_rel(1200);
        check(irq_n == 1'b1, "R8 disabled", int'(irq_n), 1);
        reg_wr(2'd2, 8'h01);

        // R9: rewrite after fire does not retrigger
        expect_fire(420, "R9 first fire");
        pulse_frame();
        wait_rel(430);
        reg_wr(2'd3, 8'h00);
        set_target(8'd60, 8'd2);
        wait_rel(1200);
        check(irq_n == 1'b1, "R9 no retrigger", int'(irq_n), 1);
        reg_rd(2'd3, d);
        check(d == 8'h40, "R9 fired flag", int'(d), 'h40);

        // R7 then R6: blocked line 244, then line 0 target fires on line 261
        set_target(8'd30, 8'd244);
        pulse_frame();
        wait_rel(85250);
        check(irq_n == 1'b1, "R7 blocked", int'(irq_n), 1);
        set_target(8'd5, 8'd0);
        expect_fire(89311, "R6 line0 to 261");
        wait_rel(89330);
        check(sb.size() == 0, "R6 wrap fire seen", sb.size(), 0);
        reg_rd(2'd3, d);
        check(d[7] == 1'b1, "R6 pending", int'(d[7]), 1);

        // R4: code 255 -> line 240, dot 40 borrows to line 239 dot 339
        set_target(8'd20, 8'd255);
        expect_fire(81839, "R4 code 255");
        pulse_frame();
        wait_rel(81850);
        check(sb.size() == 0, "R4 code255 seen", sb.size(), 0);
        reg_wr(2'd3, 8'h00);
        set_target(8'd0, 8'd250);
        wait_rel(85500);
        check(irq_n == 1'b1, "R9 late rewrite", int'(irq_n), 1);

        finish_run();
    end

endmodule